// File: doc/BRIEF.md
# Tagged Memory Access Checker

This block guards one 4 KiB page of byte-addressable data memory. The memory is split into 16-byte granules, and the block keeps one 4-bit allocation tag for each granule. Every load or store arrives with a 64-bit pointer. The block takes a 4-bit key from that pointer and compares it with the allocation tag of the granule the pointer targets. A matching access completes normally. A mismatching access is suppressed and reported as a tag-check fault. A separate set-tag command writes the pointer's key into the tag of the addressed granule.

A requester drives one request per cycle on a valid/ready handshake. Each request carries an operation code, the pointer and a write byte. The block answers exactly one cycle later with the read byte, a fault flag, an out-of-page flag and the granule's stored tag. Pointer bits 55:12 must equal a configured page base. When they do not, the request has no effect and is reported as out of range, which is distinct from a tag fault.

Top module: `tagged_access_checker`

## Requirements
- R1: After reset every allocation tag is 0 and `rsp_valid`, `rsp_fault` and `rsp_range_err` are 0. In consequence, a load with key 0 to any in-page address does not fault.
- R2: `req_ready` is always 1. Each cycle with `req_valid` high is followed, one cycle later, by exactly one cycle of `rsp_valid` high. A cycle without a request is followed by `rsp_valid` low.
- R3: The key is pointer bits 59:56. Pointer bits 63:60 have no effect on the tag check or on addressing.
- R4: Pointer bits 11:4 select one of 256 granules, and bits 11:0 select the byte. One tag covers all 16 bytes of a granule, including the last granule at offsets 0xFF0 to 0xFFF.
- R5: A load (op 2'b00) whose key equals the granule's tag returns the stored byte on `rsp_rdata`, with `rsp_fault`=0 and `rsp_tag` equal to the granule's tag.
- R6: A store (op 2'b01) whose key matches writes `req_wdata` into the addressed byte, with `rsp_fault`=0.
- R7: A load whose key differs from the granule's tag gives `rsp_fault`=1 and `rsp_rdata`=0.
- R8: A store whose key differs gives `rsp_fault`=1 and leaves the memory byte unchanged.
- R9: A set-tag (op 2'b10) never faults. It writes the key into the granule's tag, and `rsp_tag` reports the tag held before the write. The new tag applies to a request accepted in the very next cycle.
- R10: A load, store or set-tag whose pointer bits 55:12 differ from `cfg_page_base` gives `rsp_range_err`=1, `rsp_fault`=0, `rsp_rdata`=0 and `rsp_tag`=0. It changes neither memory nor tags.
- R11: Op 2'b11 is reserved. It changes nothing, and it raises neither `rsp_fault` nor `rsp_range_err`.
- R12: `rsp_fault` and `rsp_range_err` are high only in a cycle with `rsp_valid` high. Each lasts one cycle per offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_base | input | 44 | Expected value of pointer bits 55:12 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken (always 1) |
| req_op | input | 2 | 00 load, 01 store, 10 set-tag, 11 reserved |
| req_ptr | input | 64 | Tagged pointer |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 8 | Load data, 0 unless a matching load |
| rsp_fault | output | 1 | Tag-check fault pulse |
| rsp_range_err | output | 1 | Out-of-page pulse |
| rsp_tag | output | 4 | Allocation tag of the addressed granule at acceptance |

## Verification
The critical overlap is a tag write and a tag lookup on the same granule. A set-tag writes the tag at the same clock edge that the next request's lookup is prepared for. The bench provokes this with a set-tag to a granule followed, in the immediately next cycle, by a load to that granule that carries the new key. A pass needs no fault on the load and the new tag on `rsp_tag`, while the set-tag's own response reports the old tag. A forged-key store followed by a correct-key read-back shows that a fault suppresses the write, and an out-of-page set-tag followed by an in-page load shows that such a request is refused.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD   = 2'b00,
      OP_STORE  = 2'b01,
      OP_SETTAG = 2'b10,
      OP_RSVD   = 2'b11
   } tmc_op_e;
endpackage

// File: rtl/tmc_ptr_decode.sv
module tmc_ptr_decode #(
   parameter int PTR_W      = 64,
   parameter int TAG_W      = 4,
   parameter int TAG_LSB    = 56,
   parameter int PAGE_BITS  = 12,
   parameter int GRAN_BITS  = 4,
   parameter bit CHECK_PAGE = 1'b1,
   localparam int IDX_W     = PAGE_BITS - GRAN_BITS,
   localparam int BASE_W    = TAG_LSB - PAGE_BITS
) (
   input  logic [PTR_W-1:0]     ptr,
   input  logic [BASE_W-1:0]    page_base,
   output logic [TAG_W-1:0]     key,
   output logic [IDX_W-1:0]     gidx,
   output logic [PAGE_BITS-1:0] boff,
   output logic                 in_page
);
   logic unused_top;

   assign key        = ptr[TAG_LSB +: TAG_W];
   assign boff       = ptr[PAGE_BITS-1:0];
   assign gidx       = ptr[PAGE_BITS-1:GRAN_BITS];
   assign unused_top = ^ptr[PTR_W-1:TAG_LSB+TAG_W];

   generate
      if (CHECK_PAGE) begin : g_page_chk
         assign in_page = (ptr[TAG_LSB-1:PAGE_BITS] == page_base);
      end else begin : g_page_any
         logic unused_base;
         assign unused_base = ^{page_base, ptr[TAG_LSB-1:PAGE_BITS]};
         assign in_page     = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tmc_tag_store.sv
module tmc_tag_store #(
   parameter int TAG_W     = 4,
   parameter int IDX_W     = 8,
   localparam int ENTRIES  = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [TAG_W-1:0] tags [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tags[i] <= '0;
         end
      end else if (wr_en) begin
         tags[wr_idx] <= wr_tag;
      end
   end

   assign rd_tag = tags[rd_idx];
endmodule

// File: rtl/tmc_byte_ram.sv
module tmc_byte_ram #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 12,
   localparam int DEPTH   = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[addr] <= wdata;
      end
      if (rd_en) begin
         rdata <= mem[addr];
      end
   end
endmodule

// File: rtl/tagged_access_checker.sv
module tagged_access_checker #(
   parameter int PTR_W      = 64,
   parameter int TAG_W      = 4,
   parameter int TAG_LSB    = 56,
   parameter int PAGE_BITS  = 12,
   parameter int GRAN_BITS  = 4,
   parameter int DATA_W     = 8,
   parameter bit CHECK_PAGE = 1'b1,
   localparam int IDX_W     = PAGE_BITS - GRAN_BITS,
   localparam int BASE_W    = TAG_LSB - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] cfg_page_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [PTR_W-1:0]  req_ptr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_fault,
   output logic              rsp_range_err,
   output logic [TAG_W-1:0]  rsp_tag
);
   import tmc_pkg::*;

   generate
      if (TAG_LSB + TAG_W >= PTR_W) begin : g_bad_tag_pos
         $error("tag field must sit below the pointer top bit");
      end
      if (GRAN_BITS < 1 || GRAN_BITS >= PAGE_BITS) begin : g_bad_gran
         $error("granule must be smaller than the page");
      end
      if (PAGE_BITS >= TAG_LSB) begin : g_bad_page
         $error("page bits must lie below the tag field");
      end
      if (PAGE_BITS > 16) begin : g_big_page
         $error("page too large for on-block memory");
      end
   endgenerate

   logic [TAG_W-1:0]     key;
   logic [IDX_W-1:0]     gidx;
   logic [PAGE_BITS-1:0] boff;
   logic                 in_page;
   logic [TAG_W-1:0]     lkp_tag;
   logic [DATA_W-1:0]    ram_rdata;

   tmc_op_e op;
   logic    accept, is_mem, is_ld, is_st, is_set;
   logic    tag_ok, hit, fault_d, range_d, tag_wr;

   tmc_ptr_decode #(
      .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB),
      .PAGE_BITS(PAGE_BITS), .GRAN_BITS(GRAN_BITS), .CHECK_PAGE(CHECK_PAGE)
   ) i_dec (
      .ptr(req_ptr), .page_base(cfg_page_base),
      .key(key), .gidx(gidx), .boff(boff), .in_page(in_page)
   );

   assign req_ready = 1'b1;
   assign op        = tmc_op_e'(req_op);
   assign accept    = req_valid & req_ready;
   assign is_ld     = (op == OP_LOAD);
   assign is_st     = (op == OP_STORE);
   assign is_set    = (op == OP_SETTAG);
   assign is_mem    = is_ld | is_st;
   assign tag_ok    = (key == lkp_tag);
   assign hit       = accept & in_page & is_mem & tag_ok;
   assign fault_d   = accept & in_page & is_mem & ~tag_ok;
   assign range_d   = accept & ~in_page & (op != OP_RSVD);
   assign tag_wr    = accept & in_page & is_set;

   tmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) i_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(gidx), .rd_tag(lkp_tag),
      .wr_en(tag_wr), .wr_idx(gidx), .wr_tag(key)
   );

   tmc_byte_ram #(.DATA_W(DATA_W), .ADDR_W(PAGE_BITS)) i_ram (
      .clk(clk), .wr_en(hit & is_st), .rd_en(hit & is_ld),
      .addr(boff), .wdata(req_wdata), .rdata(ram_rdata)
   );

   logic ld_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_fault     <= 1'b0;
         rsp_range_err <= 1'b0;
         rsp_tag       <= '0;
         ld_ok_q       <= 1'b0;
      end else begin
         rsp_valid     <= accept;
         rsp_fault     <= fault_d;
         rsp_range_err <= range_d;
         rsp_tag       <= (accept & in_page) ? lkp_tag : '0;
         ld_ok_q       <= hit & is_ld;
      end
   end

   assign rsp_rdata = ld_ok_q ? ram_rdata : '0;
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker #(
   parameter int PTR_W      = 64,
   parameter int TAG_W      = 4,
   parameter int TAG_LSB    = 56,
   parameter int PAGE_BITS  = 12,
   parameter int DATA_W     = 8,
   parameter bit CHECK_PAGE = 1'b1,
   localparam int BASE_W    = TAG_LSB - PAGE_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BASE_W-1:0] cfg_page_base,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic [PTR_W-1:0]  req_ptr,
   input logic [TAG_W-1:0]  lkp_tag,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_fault,
   input logic              rsp_range_err
);
   logic             c_in_page, c_mem, unused_c;
   logic [TAG_W-1:0] c_key;

   assign c_key     = req_ptr[TAG_LSB +: TAG_W];
   assign c_in_page = CHECK_PAGE ? (req_ptr[TAG_LSB-1:PAGE_BITS] == cfg_page_base) : 1'b1;
   assign c_mem     = (req_op == 2'b00) || (req_op == 2'b01);
   assign unused_c  = ^{req_ptr[PTR_W-1:TAG_LSB+TAG_W], req_ptr[PAGE_BITS-1:0]};

   AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid); // R2
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_MATCH_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && c_mem && c_in_page && c_key == lkp_tag) |=> !rsp_fault); // R5
   AST_MISMATCH_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && c_mem && c_in_page && c_key != lkp_tag) |=> rsp_fault); // R7
   AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_rdata == '0)); // R7
   AST_SETTAG_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b10) |=> !rsp_fault); // R9
   AST_OUT_OF_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !c_in_page && req_op != 2'b11) |=> (rsp_range_err && !rsp_fault && rsp_rdata == '0)); // R10
   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b11) |=> (!rsp_fault && !rsp_range_err)); // R11
   AST_FLAG_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_range_err) |-> rsp_valid); // R12
endmodule

bind tagged_access_checker tmc_checker #(
   .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB),
   .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W), .CHECK_PAGE(CHECK_PAGE)
) i_tmc_checker (
   .clk(clk), .rst_n(rst_n), .cfg_page_base(cfg_page_base),
   .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
   .req_ptr(req_ptr), .lkp_tag(lkp_tag), .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .rsp_range_err(rsp_range_err)
);

// File: tb/test_tagged_access_checker.sv
module test_tagged_access_checker;
   localparam logic [43:0] BASE = 44'h0_0001_0000;
   localparam logic [1:0]  LD = 2'b00, ST = 2'b01, SETT = 2'b10, RSV = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'b00;
   logic [63:0] req_ptr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid, rsp_fault, rsp_range_err;
   logic [7:0]  rsp_rdata;
   logic [3:0]  rsp_tag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic       r_valid, r_fault, r_rerr;
   logic [7:0] r_rdata;
   logic [3:0] r_tag;

   always #10 clk = ~clk;

   tagged_access_checker i_tagged_access_checker (
      .clk(clk), .rst_n(rst_n), .cfg_page_base(BASE),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_ptr(req_ptr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
      .rsp_range_err(rsp_range_err), .rsp_tag(rsp_tag)
   );

   function automatic logic [63:0] mkptr(logic [3:0] top, logic [3:0] key,
                                         logic [43:0] base, logic [11:0] off);
      return {top, key, base, off};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic grab();
      r_valid = rsp_valid; r_fault = rsp_fault; r_rerr = rsp_range_err;
      r_rdata = rsp_rdata; r_tag = rsp_tag;
   endtask

   // called at a negedge; returns at the negedge after acceptance with response captured
   task automatic xfer(logic [1:0] op, logic [63:0] p, logic [7:0] d);
      req_valid = 1'b1; req_op = op; req_ptr = p; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      grab();
   endtask

   task automatic t_reset();
      chk("R1 rsp_valid after reset", rsp_valid, 0);
      chk("R1 fault after reset", rsp_fault, 0);
      chk("R2 ready", req_ready, 1);
      xfer(LD, mkptr(4'h0, 4'h0, BASE, 12'h039), 8'h00);
      chk("R2 rsp_valid one cycle later", r_valid, 1);
      chk("R1 key0 load no fault", r_fault, 0);
      chk("R1 reset tag zero", r_tag, 0);
      @(negedge clk);
      chk("R2 no response when idle", rsp_valid, 0);
   endtask

   task automatic t_set_store_load();
      xfer(SETT, mkptr(4'h0, 4'h5, BASE, 12'h030), 8'h00);
      chk("R9 set-tag no fault", r_fault, 0);
      chk("R9 set-tag reports old tag", r_tag, 0);
      xfer(ST, mkptr(4'h0, 4'h5, BASE, 12'h039), 8'hA5);
      chk("R6 matching store no fault", r_fault, 0);
      xfer(LD, mkptr(4'h0, 4'h5, BASE, 12'h039), 8'h00);
      chk("R5 matching load data", r_rdata, 8'hA5);
      chk("R5 matching load no fault", r_fault, 0);
      chk("R5 stored tag", r_tag, 4'h5);
      xfer(LD, mkptr(4'h0, 4'h5, BASE, 12'h03F), 8'h00);
      chk("R4 last byte of granule shares tag", r_fault, 0);
      xfer(LD, mkptr(4'h0, 4'h5, BASE, 12'h040), 8'h00);
      chk("R4 neighbour granule keeps tag 0", r_fault, 1);
      chk("R4 neighbour granule tag", r_tag, 0);
   endtask

   task automatic t_forgery();
      xfer(LD, mkptr(4'h0, 4'h6, BASE, 12'h039), 8'h00);
      chk("R7 forged load faults", r_fault, 1);
      chk("R7 forged load data zero", r_rdata, 0);
      @(negedge clk);
      chk("R12 fault lasts one cycle", rsp_fault, 0);
      xfer(ST, mkptr(4'h0, 4'h6, BASE, 12'h039), 8'h3C);
      chk("R8 forged store faults", r_fault, 1);
      xfer(LD, mkptr(4'h0, 4'h5, BASE, 12'h039), 8'h00);
      chk("R8 memory unchanged after forged store", r_rdata, 8'hA5);
   endtask

   task automatic t_top_bits();
      xfer(LD, mkptr(4'hF, 4'h5, BASE, 12'h039), 8'h00);
      chk("R3 bits 63:60 ignored fault", r_fault, 0);
      chk("R3 bits 63:60 ignored data", r_rdata, 8'hA5);
      xfer(LD, mkptr(4'h5, 4'h0, BASE, 12'h039), 8'h00);
      chk("R3 key only from bits 59:56", r_fault, 1);
   endtask

   task automatic t_range();
      xfer(LD, mkptr(4'h0, 4'h5, BASE + 44'd1, 12'h039), 8'h00);
      chk("R10 range err flag", r_rerr, 1);
      chk("R10 no tag fault", r_fault, 0);
      chk("R10 data zero", r_rdata, 0);
      chk("R10 tag zero", r_tag, 0);
      @(negedge clk);
      chk("R12 range err one cycle", rsp_range_err, 0);
      xfer(ST, mkptr(4'h0, 4'h5, BASE + 44'd1, 12'h039), 8'h11);
      chk("R10 store range err", r_rerr, 1);
      xfer(SETT, mkptr(4'h0, 4'h9, BASE ^ 44'h800_0000_0000, 12'h030), 8'h00);
      chk("R10 set-tag range err", r_rerr, 1);
      xfer(LD, mkptr(4'h0, 4'h5, BASE, 12'h039), 8'h00);
      chk("R10 tag kept after refused set-tag", r_fault, 0);
      chk("R10 data kept after refused store", r_rdata, 8'hA5);
   endtask

   task automatic t_reserved();
      xfer(RSV, mkptr(4'h0, 4'h6, BASE, 12'h039), 8'h22);
      chk("R11 reserved responds", r_valid, 1);
      chk("R11 reserved no fault", r_fault, 0);
      chk("R11 reserved no range err", r_rerr, 0);
      xfer(RSV, mkptr(4'h0, 4'h6, BASE + 44'd3, 12'h039), 8'h22);
      chk("R11 reserved out of page no range err", r_rerr, 0);
      xfer(LD, mkptr(4'h0, 4'h5, BASE, 12'h039), 8'h00);
      chk("R11 reserved left memory and tag", {r_fault, r_rdata}, {1'b0, 8'hA5});
   endtask

   task automatic t_back_to_back();
      req_valid = 1'b1; req_op = SETT; req_ptr = mkptr(4'h0, 4'hA, BASE, 12'h7F0);
      @(posedge clk);
      @(negedge clk);
      grab();
      req_op = LD; req_ptr = mkptr(4'h0, 4'hA, BASE, 12'h7F5);
      chk("R9 set-tag response old tag", r_tag, 0);
      chk("R9 set-tag response valid", r_valid, 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      grab();
      chk("R9 next-cycle load sees new tag", r_fault, 0);
      chk("R9 next-cycle load tag", r_tag, 4'hA);
      chk("R2 back-to-back second response", r_valid, 1);
   endtask

   task automatic t_last_granule();
      xfer(SETT, mkptr(4'h0, 4'hF, BASE, 12'hFF0), 8'h00);
      xfer(ST, mkptr(4'h0, 4'hF, BASE, 12'hFFF), 8'h77);
      chk("R4 last granule store", r_fault, 0);
      xfer(LD, mkptr(4'h0, 4'hF, BASE, 12'hFFF), 8'h00);
      chk("R4 last granule load", r_rdata, 8'h77);
      xfer(LD, mkptr(4'h0, 4'hF, BASE, 12'hFEF), 8'h00);
      chk("R4 granule below last still tag 0", r_fault, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_store_load();
      t_forgery();
      t_top_bits();
      t_range();
      t_reserved();
      t_back_to_back();
      t_last_granule();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule